// File: doc/BRIEF.md
# Fibonacci of Integer Square Root Unit

This sequential unit accepts a 32-bit unsigned operand on a start pulse. It first finds the integer square root of the operand. The root comes from a bisection over the candidate interval [0, 2^16). Each probe squares the midpoint with a shift-and-add loop that reuses a single adder, so the block contains no multiplier. The unit then uses the root as an iteration count. It steps a pair of Fibonacci registers by feedback that many times and returns the Fibonacci number of the root, reduced modulo 2^32.

A caller waits for the unit to be idle and pulses `start` with `nIn` valid in the same cycle. Some cycles later `done` pulses for one cycle. At that point `result` holds F(root) and `root` holds the square root, which is exposed for debug. Both outputs keep their values until the next accepted start. The run time depends only on the root, so a caller can predict it exactly.

Top module: `fib_of_root`

## Requirements
- R1: After `done`, `root` equals floor(sqrt(`nIn`)) for every 32-bit value of `nIn`. This includes 0→0, 1→1, exact roots of perfect squares, and 2^32-1→65535.
- R2: After `done`, `result` equals F(`root`) mod 2^32, with F(0)=0, F(1)=1 and F(k)=F(k-1)+F(k-2). Sums that exceed 32 bits wrap and do not saturate; for example, a root of 48 yields 512559680.
- R3: `done` is high for exactly one cycle per accepted start. The unit reports busy without a break from the cycle after the accepted start until `done`.
- R4: A `start` pulse that arrives while the unit is busy is ignored. The running computation keeps its operand and its timing.
- R5: Between `done` and the next accepted start, `result` and `root` do not change.
- R6: While reset is held and after its release, `done` is low, `result` is 0 and `root` is 0.
- R7: Let edge 0 be the clock edge that samples an accepted start. `done` is first observed high after clock edge 306+`root`. This count covers 16 search steps of 19 cycles each, 2 cycles of turnaround, and one cycle per Fibonacci iteration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request; accepted only while idle |
| nIn | input | 32 | Unsigned operand, sampled with an accepted start |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | F(root) modulo 2^32, held until next start |
| root | output | 16 | Integer square root of the operand (debug) |

## Verification
A wrong bound update or a bad square in the search shows up as a wrong `root`. That error also moves the `done` edge, because the Fibonacci phase takes one cycle per unit of root. Every run therefore checks the search through two independent port observations at once. A wrong iteration count or feedback step in the Fibonacci pair shows up as a `result` that is off by one index or that lacks wraparound, and it shows up in the same `done` cycle. A control fault that re-arms on a stray start changes the root, the result and the latency of the run that is already in progress, so it is visible within one run.

// File: rtl/fibsqrt_pkg.sv
package fibsqrt_pkg;

  // Strobes sent from the sequencer to the datapath, at most one per cycle
  typedef struct packed {
    logic loadInit;  // capture operand, open search interval, seed Fibonacci pair
    logic loadMid;   // begin squaring the current midpoint
    logic sqStep;    // one shift-and-add step
    logic decide;    // narrow the interval with the finished square
    logic fibStep;   // advance the Fibonacci pair once
  } fsrStrobe_t;

endpackage

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fibsqrt_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int RES_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  fsrStrobe_t          strobe,
  input  logic [IN_W-1:0]     nIn,
  output logic                rangeDone,
  output logic                sqLast,
  output logic                fibLast,
  output logic [IN_W/2-1:0]   root,
  output logic [RES_W-1:0]    result
);

  localparam int ROOT_W   = IN_W / 2;
  localparam int BND_W    = ROOT_W + 1;
  localparam int ACC_W    = IN_W + 1;
  localparam int SQ_STEPS = BND_W;
  localparam int CNT_W    = $clog2(SQ_STEPS + 1);

  logic [IN_W-1:0]   nReg;
  logic [BND_W-1:0]  lo, hi;
  logic [BND_W:0]    midSum;
  logic [BND_W-1:0]  mid;
  logic [ACC_W-1:0]  mcand, acc;
  logic [BND_W-1:0]  mplier;
  logic [CNT_W-1:0]  sqCnt;
  logic [RES_W-1:0]  fibPrev, fibCur;
  logic [ROOT_W-1:0] fibCnt;

  assign midSum    = {1'b0, lo} + {1'b0, hi};
  assign mid       = midSum[BND_W:1];
  assign rangeDone = (hi - lo) == BND_W'(1);
  assign sqLast    = sqCnt == CNT_W'(SQ_STEPS - 1);
  assign fibLast   = fibCnt == lo[ROOT_W-1:0];
  assign root      = lo[ROOT_W-1:0];
  assign result    = fibCur;

  // Search interval and operand
  always_ff @(posedge clk) begin
    if (rst) begin
      nReg <= '0;
      lo   <= '0;
      hi   <= '0;
    end else if (strobe.loadInit) begin
      nReg <= nIn;
      lo   <= '0;
      hi   <= BND_W'(1) << ROOT_W;
    end else if (strobe.decide) begin
      if (acc <= {1'b0, nReg}) lo <= mid;
      else                     hi <= mid;
    end
  end

  // Multiplier-free squaring: shift-and-add over one adder
  always_ff @(posedge clk) begin
    if (rst) begin
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      sqCnt  <= '0;
    end else if (strobe.loadMid) begin
      mcand  <= ACC_W'(mid);
      mplier <= mid;
      acc    <= '0;
      sqCnt  <= '0;
    end else if (strobe.sqStep) begin
      if (mplier[0]) acc <= acc + mcand;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
      sqCnt  <= sqCnt + CNT_W'(1);
    end
  end

  // Fibonacci register pair, seeded so that zero steps leave F(0)
  always_ff @(posedge clk) begin
    if (rst || strobe.loadInit) begin
      fibPrev <= RES_W'(1);
      fibCur  <= '0;
      fibCnt  <= '0;
    end else if (strobe.fibStep) begin
      fibCur  <= fibCur + fibPrev;
      fibPrev <= fibCur;
      fibCnt  <= fibCnt + ROOT_W'(1);
    end
  end

endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fibsqrt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       rangeDone,
  input  logic       sqLast,
  input  logic       fibLast,
  output fsrStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_SQUARE, S_DECIDE, S_FIB, S_FINISH
  } fsrState_t;

  fsrState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: if (start) begin
        strobe.loadInit = 1'b1;
        nextState       = S_CHECK;
      end
      S_CHECK: if (rangeDone) begin
        nextState = S_FIB;
      end else begin
        strobe.loadMid = 1'b1;
        nextState      = S_SQUARE;
      end
      S_SQUARE: begin
        strobe.sqStep = 1'b1;
        if (sqLast) nextState = S_DECIDE;
      end
      S_DECIDE: begin
        strobe.decide = 1'b1;
        nextState     = S_CHECK;
      end
      S_FIB: if (fibLast) nextState = S_FINISH;
             else         strobe.fibStep = 1'b1;
      S_FINISH: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  assign busy = state != S_IDLE;
  assign done = state == S_FINISH;

endmodule

// File: rtl/fib_of_root.sv
module fib_of_root
  import fibsqrt_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int RES_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IN_W-1:0]   nIn,
  output logic              done,
  output logic [RES_W-1:0]  result,
  output logic [IN_W/2-1:0] root
);

  fsrStrobe_t strobe;
  logic rangeDone, sqLast, fibLast, busy;

  fsr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .rangeDone(rangeDone), .sqLast(sqLast), .fibLast(fibLast),
    .strobe(strobe), .busy(busy), .done(done)
  );

  fsr_datapath #(.IN_W(IN_W), .RES_W(RES_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .nIn(nIn),
    .rangeDone(rangeDone), .sqLast(sqLast), .fibLast(fibLast),
    .root(root), .result(result)
  );

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int IN_W  = 32,
  parameter int RES_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [RES_W-1:0]  result,
  input logic [IN_W/2-1:0] root
);

  // R3: completion is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: done only appears while the sequencer is busy
  p_done_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  // R3/R4: busy is not dropped before done, whatever start does
  p_busy_until_done_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);

  // R5: outputs hold through the done cycle and while idle without start
  p_hold_after_done_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> ($stable(result) && $stable(root)));

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(result) && $stable(root)));

  // R2: an accepted start reseeds to F(0) and an empty interval bottom
  p_start_reseed_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && result == '0 && root == '0));

endmodule

bind fib_of_root fsr_checker #(.IN_W(IN_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .done(done), .result(result), .root(root)
);

// File: tb/fib_of_root_test.sv
module fib_of_root_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] nIn = '0;
  logic        done;
  logic [31:0] result;
  logic [15:0] root;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  fib_of_root uut (
    .clk(clk), .rst(rst), .start(start), .nIn(nIn),
    .done(done), .result(result), .root(root)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] refRoot(input logic [31:0] n);
    logic [32:0] l = 0, h = 33'h10000, m;
    while (h - l > 1) begin
      m = (l + h) >> 1;
      if ({31'd0, m} * {31'd0, m} <= {32'd0, n}) l = m; else h = m;
    end
    return l[31:0];
  endfunction

  function automatic logic [31:0] refFib(input logic [31:0] k);
    logic [31:0] a = 0, b = 1, t;
    for (int i = 0; i < k; i++) begin
      t = a + b; b = a; a = t;
    end
    return a;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
    end
  endtask

  // Run one operand; optionally pulse a stray start while busy (R4)
  task automatic runOne(input logic [31:0] n, input bit stray);
    int k = 0;
    logic [31:0] r = refRoot(n);
    logic [31:0] f = refFib(r);
    logic [31:0] heldRes;
    logic [15:0] heldRoot;
    @(negedge clk); start = 1'b1; nIn = n;
    @(negedge clk); start = 1'b0; nIn = ~n;
    while (!done && k < 70000) begin
      if (stray && k == 40) begin start = 1'b1; nIn = n ^ 32'h00F0_0F00; end
      else start = 1'b0;
      @(negedge clk); k++;
    end
    start = 1'b0;
    check(stray ? "R4 latency" : "R7 latency", k, 306 + r);
    check(stray ? "R4 root" : "R1 root", root, r);
    check("R2 result", result, f);
    heldRes = result; heldRoot = root;
    @(negedge clk);
    check("R3 done pulse", done, 0);
    repeat (3) @(negedge clk);
    check("R5 hold result", result, heldRes);
    check("R5 hold root", root, heldRoot);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R6 done in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 result", result, 0);
    check("R6 root", root, 0);
    check("R6 done", done, 0);

    // Near-exhaustive sweep over small operands
    for (int n = 0; n <= 120; n++) runOne(n, 0);
    // Perfect squares, neighbours and wrap points
    runOne(32'd2209, 0);  // root 47, largest unwrapped
    runOne(32'd2304, 0);  // root 48, first wrap
    runOne(32'd2303, 0);
    runOne(32'd65535, 0);
    runOne(32'd65536, 0);
    // Stray start while busy
    runOne(32'd100, 1);
    runOne(32'd17, 1);
    // Scattered operands with moderate roots
    for (int i = 0; i < 12; i++) runOne(($urandom & 32'h3FFFF) | (i << 12), 0);
    // Largest operand
    runOne(32'hFFFF_FFFF, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule